// File: doc/BRIEF.md
# Integer Register File with Deferred Fault Tags

This block is an integer register file with a small execute stage attached. Every entry holds a data word and one extra tag bit. The tag marks a value that came from a faulted speculative load. A speculative load that hits an error does not trap. Instead it writes its destination with the tag set. From there the tag spreads into every result computed from that value. The fault is reported only when an explicit check operation finds the tag on a register. That lets a scheduler hoist loads above the branches that guard them without taking a trap on a path that is never used.

Each issued operation carries a one-bit predicate. When the predicate is low, the operation changes nothing. The block has two combinational read ports and one internal write port, which is fed by a writeback register one cycle behind issue. A read of the register that is waiting in that writeback register returns the pending value through a bypass. The fault, check and compare outputs are registered. They appear in the cycle after issue.

Top module: `tagged_regfile`

## Requirements
- R1: After reset every register reads as data 0 with the tag clear, and `fault_now`, `chk_fault` and `cmp_valid` are 0.
- R2: Operations with clean sources compute their result: opcode 1 a+b, 2 a-b, 3 a&b, 4 a^b, 5 move a, and 6 conditional move. The conditional move writes a when b is nonzero and leaves the destination unchanged when b is zero. All of these results have the tag clear.
- R3: For opcodes 1 to 5, the result tag is the OR of the source tags. Opcode 6 writes a tagged result if either source is tagged. A tagged result is always written with data 0.
- R4: A speculative load (opcode 7) writes `ld_data` to the destination. If `ld_err` is set or the address register (a) is tagged, the destination is written tagged with data 0, and `fault_now` stays 0.
- R5: A normal load (opcode 8) pulses `fault_now` and writes nothing when `ld_err` is set or a is tagged. Otherwise it writes `ld_data` with the tag clear. A store (opcode 9) pulses `fault_now` when its address register a is tagged and never writes a register.
- R6: A check (opcode 10) on a tagged register a pulses `chk_fault` and puts the index of a on `chk_reg`. On a clean register it gives no pulse. It never modifies any register.
- R7: A compare (opcode 11) sets `cmp_valid`. With clean sources it drives `cmp_pt` = (a==b) and `cmp_pf` = (a!=b). If either source is tagged, both predicate outputs are 0.
- R8: An issued operation with `pred` low writes no register and raises none of `fault_now`, `chk_fault` or `cmp_valid`.
- R9: Register 0 always reads as data 0 with the tag clear, on both ports. Writes to register 0 are dropped.
- R10: A register written by the operation issued in the previous cycle is seen by the read ports and by the next operation with its new value and tag, before the array itself is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation code (encodings in R2 to R7; 0 and 12 to 15 do nothing) |
| pred | input | 1 | Qualifying predicate; low disables the operation |
| src_a | input | 7 | Read port A index, also the address or checked register |
| src_b | input | 7 | Read port B index |
| dst | input | 7 | Destination register index |
| ld_data | input | 64 | Data returned for a load |
| ld_err | input | 1 | Error flag returned with a load |
| rd_a_data | output | 64 | Read port A data |
| rd_a_tag | output | 1 | Read port A tag |
| rd_b_data | output | 64 | Read port B data |
| rd_b_tag | output | 1 | Read port B tag |
| fault_now | output | 1 | Immediate fault from a load or store |
| chk_fault | output | 1 | Deferred fault raised by a check |
| chk_reg | output | 7 | Register index that the check found tagged |
| cmp_valid | output | 1 | A compare completed |
| cmp_pt | output | 1 | Compare true predicate |
| cmp_pf | output | 1 | Compare false predicate |

## Verification
The assertions assume that `issue`, `opcode`, `pred` and the indices are stable over a whole clock cycle. They also assume that `ld_data` and `ld_err` belong to the operation issued in the same cycle. The stimulus changes every input only on the falling edge and holds it through the next rising edge. It never mixes a load response with an operation of another cycle. Operations are issued back to back or with idle cycles between them. Idle cycles are used to read registers through port A without disturbing the pending write.

// File: rtl/tagged_regfile.sv
module tagged_regfile #(
  parameter int NREG = 128,
  parameter int W = 64,
  localparam int IW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [3:0]    opcode,
  input  logic          pred,
  input  logic [IW-1:0] src_a,
  input  logic [IW-1:0] src_b,
  input  logic [IW-1:0] dst,
  input  logic [W-1:0]  ld_data,
  input  logic          ld_err,
  output logic [W-1:0]  rd_a_data,
  output logic          rd_a_tag,
  output logic [W-1:0]  rd_b_data,
  output logic          rd_b_tag,
  output logic          fault_now,
  output logic          chk_fault,
  output logic [IW-1:0] chk_reg,
  output logic          cmp_valid,
  output logic          cmp_pt,
  output logic          cmp_pf
);
  localparam logic [3:0] OP_ADD = 4'd1, OP_SUB = 4'd2, OP_AND = 4'd3, OP_XOR = 4'd4,
                         OP_MOV = 4'd5, OP_CMOV = 4'd6, OP_LDS = 4'd7, OP_LD = 4'd8,
                         OP_ST = 4'd9, OP_CHK = 4'd10, OP_CMP = 4'd11;

  logic [W:0]    mem [NREG];
  logic          wb_we, wb_tag;
  logic [IW-1:0] wb_idx;
  logic [W-1:0]  wb_data;

  assign {rd_a_tag, rd_a_data} = (src_a == '0) ? '0 :
                                 (wb_we && wb_idx == src_a) ? {wb_tag, wb_data} : mem[src_a];
  assign {rd_b_tag, rd_b_data} = (src_b == '0) ? '0 :
                                 (wb_we && wb_idx == src_b) ? {wb_tag, wb_data} : mem[src_b];

  wire go = issue && pred;
  wire any_tag = rd_a_tag | rd_b_tag;

  logic          x_we, x_tag, x_flt, x_chk, x_cmp;
  logic [W-1:0]  x_val;

  always_comb begin
    x_we = 1'b0; x_tag = 1'b0; x_flt = 1'b0; x_chk = 1'b0; x_cmp = 1'b0;
    x_val = '0;
    case (opcode)
      OP_ADD:  begin x_we = 1'b1; x_val = rd_a_data + rd_b_data; x_tag = any_tag; end
      OP_SUB:  begin x_we = 1'b1; x_val = rd_a_data - rd_b_data; x_tag = any_tag; end
      OP_AND:  begin x_we = 1'b1; x_val = rd_a_data & rd_b_data; x_tag = any_tag; end
      OP_XOR:  begin x_we = 1'b1; x_val = rd_a_data ^ rd_b_data; x_tag = any_tag; end
      OP_MOV:  begin x_we = 1'b1; x_val = rd_a_data; x_tag = rd_a_tag; end
      OP_CMOV: begin
        x_we = any_tag || (rd_b_data != '0);
        x_val = rd_a_data; x_tag = any_tag;
      end
      OP_LDS:  begin x_we = 1'b1; x_val = ld_data; x_tag = rd_a_tag | ld_err; end
      OP_LD:   begin
        x_flt = rd_a_tag | ld_err;
        x_we = !x_flt; x_val = ld_data;
      end
      OP_ST:   x_flt = rd_a_tag;
      OP_CHK:  x_chk = rd_a_tag;
      OP_CMP:  x_cmp = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      wb_we <= 1'b0; wb_tag <= 1'b0; wb_idx <= '0; wb_data <= '0;
      fault_now <= 1'b0; chk_fault <= 1'b0; chk_reg <= '0;
      cmp_valid <= 1'b0; cmp_pt <= 1'b0; cmp_pf <= 1'b0;
    end else begin
      if (wb_we) mem[wb_idx] <= {wb_tag, wb_data};
      wb_we     <= go && x_we && (dst != '0);
      wb_idx    <= dst;
      wb_tag    <= x_tag;
      wb_data   <= x_tag ? '0 : x_val;
      fault_now <= go && x_flt;
      chk_fault <= go && x_chk;
      chk_reg   <= src_a;
      cmp_valid <= go && x_cmp;
      cmp_pt    <= go && x_cmp && !any_tag && (rd_a_data == rd_b_data);
      cmp_pf    <= go && x_cmp && !any_tag && (rd_a_data != rd_b_data);
    end
  end

  p_tagged_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && wb_tag) |-> (wb_data == '0));
  p_spec_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && opcode == OP_LDS) |=> (!fault_now && wb_we == ($past(dst) != '0)));
  p_chk_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && opcode == OP_CHK) |=> !wb_we);
  p_cmp_tagged_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && opcode == OP_CMP && any_tag) |=> (cmp_valid && !cmp_pt && !cmp_pf));
  p_pred_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !pred) |=> !(wb_we || fault_now || chk_fault || cmp_valid));
  p_no_r0_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> (wb_idx != '0));
  p_single_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_now, chk_fault, cmp_valid}));
endmodule

// File: tb/test_tagged_regfile.sv
module test_tagged_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        issue = 1'b0, pred = 1'b0, ld_err = 1'b0;
  logic [3:0]  opcode = '0;
  logic [6:0]  src_a = '0, src_b = '0, dst = '0;
  logic [63:0] ld_data = '0;
  logic [63:0] rd_a_data, rd_b_data;
  logic        rd_a_tag, rd_b_tag, fault_now, chk_fault, cmp_valid, cmp_pt, cmp_pf;
  logic [6:0]  chk_reg;
  int n_chk = 0, n_fail = 0;
  logic [63:0] d;
  logic        t;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_regfile i_tagged_regfile (
    .clk, .rst_n, .issue, .opcode, .pred, .src_a, .src_b, .dst, .ld_data, .ld_err,
    .rd_a_data, .rd_a_tag, .rd_b_data, .rd_b_tag, .fault_now, .chk_fault, .chk_reg,
    .cmp_valid, .cmp_pt, .cmp_pf);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic [3:0] code, input logic p, input logic [6:0] a, input logic [6:0] b,
                    input logic [6:0] dd, input logic [63:0] ld = '0, input logic err = 1'b0);
    @(negedge clk);
    issue = 1'b1; opcode = code; pred = p; src_a = a; src_b = b; dst = dd;
    ld_data = ld; ld_err = err;
    @(posedge clk);
    #1;
    issue = 1'b0; opcode = '0; ld_err = 1'b0;
  endtask

  task automatic rd(input logic [6:0] idx, output logic [63:0] dv, output logic tv);
    @(negedge clk);
    issue = 1'b0; src_a = idx;
    #1;
    dv = rd_a_data; tv = rd_a_tag;
  endtask

  // op(4) a(7) b(7) dst(7) expected data(64) expected tag(1)
  localparam int NV = 12;
  localparam logic [89:0] VEC [NV] = '{
    {4'd1, 7'd1,  7'd2, 7'd10, 64'd107, 1'b0},
    {4'd2, 7'd1,  7'd2, 7'd11, 64'd93,  1'b0},
    {4'd3, 7'd4,  7'd1, 7'd12, 64'd4,   1'b0},
    {4'd4, 7'd1,  7'd2, 7'd13, 64'd99,  1'b0},
    {4'd5, 7'd2,  7'd0, 7'd14, 64'd7,   1'b0},
    {4'd6, 7'd1,  7'd2, 7'd20, 64'd100, 1'b0},
    {4'd1, 7'd1,  7'd3, 7'd15, 64'd0,   1'b1},
    {4'd5, 7'd3,  7'd0, 7'd16, 64'd0,   1'b1},
    {4'd4, 7'd15, 7'd2, 7'd17, 64'd0,   1'b1},
    {4'd6, 7'd1,  7'd3, 7'd21, 64'd0,   1'b1},
    {4'd2, 7'd0,  7'd2, 7'd18, 64'hFFFF_FFFF_FFFF_FFF9, 1'b0},
    {4'd1, 7'd10, 7'd10, 7'd19, 64'd214, 1'b0}
  };

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(7'd7, d, t);
    check("R1 data", d, 0); check("R1 tag", {63'd0, t}, 0);
    check("R1 outs", {61'd0, fault_now, chk_fault, cmp_valid}, 0);

    // preload with speculative loads; R4 error path
    op(4'd7, 1, 0, 0, 1, 64'd100);
    op(4'd7, 1, 0, 0, 2, 64'd7);
    op(4'd7, 1, 0, 0, 3, 64'hDEAD, 1'b1);
    check("R4 no fault", {63'd0, fault_now}, 0);
    op(4'd7, 1, 0, 0, 4, 64'h0F0F);
    rd(7'd3, d, t);
    check("R4 data", d, 0); check("R4 tag", {63'd0, t}, 1);
    op(4'd7, 1, 3, 0, 5, 64'd55);
    rd(7'd5, d, t);
    check("R4 tagged address", {63'd0, t}, 1);

    // R2 / R3 table
    for (int k = 0; k < NV; k++) begin
      op(VEC[k][89:86], 1, VEC[k][85:79], VEC[k][78:72], VEC[k][71:65]);
      rd(VEC[k][71:65], d, t);
      check("R2/R3 data", d, VEC[k][64:1]);
      check("R2/R3 tag", {63'd0, t}, {63'd0, VEC[k][0]});
    end
    // R2 conditional move with zero condition keeps destination
    op(4'd6, 1, 2, 0, 20);
    rd(7'd20, d, t);
    check("R2 cmov hold", d, 100);

    // R5 immediate faults
    op(4'd8, 1, 1, 0, 22, 64'd9, 1'b1);
    check("R5 ld err fault", {63'd0, fault_now}, 1);
    rd(7'd22, d, t);
    check("R5 ld err no write", {d[62:0], t}, 0);
    op(4'd8, 1, 3, 0, 22, 64'd9);
    check("R5 ld tagged addr", {63'd0, fault_now}, 1);
    op(4'd9, 1, 3, 0, 0);
    check("R5 st tagged addr", {63'd0, fault_now}, 1);
    op(4'd9, 1, 1, 0, 0);
    check("R5 st clean", {63'd0, fault_now}, 0);
    op(4'd8, 1, 1, 0, 22, 64'd77);
    check("R5 ld clean", {63'd0, fault_now}, 0);
    rd(7'd22, d, t);
    check("R5 ld data", d, 77);

    // R6 check
    op(4'd10, 1, 3, 0, 3);
    check("R6 pulse", {63'd0, chk_fault}, 1);
    check("R6 index", {57'd0, chk_reg}, 3);
    rd(7'd3, d, t);
    check("R6 unchanged", {63'd0, t}, 1);
    op(4'd10, 1, 1, 0, 1);
    check("R6 clean", {63'd0, chk_fault}, 0);

    // R7 compare
    op(4'd11, 1, 1, 1, 0);
    check("R7 eq", {61'd0, cmp_valid, cmp_pt, cmp_pf}, 3'b110);
    op(4'd11, 1, 1, 2, 0);
    check("R7 ne", {61'd0, cmp_valid, cmp_pt, cmp_pf}, 3'b101);
    op(4'd11, 1, 1, 3, 0);
    check("R7 tagged", {61'd0, cmp_valid, cmp_pt, cmp_pf}, 3'b100);

    // R8 predicate off
    op(4'd1, 0, 1, 2, 1);
    rd(7'd1, d, t);
    check("R8 no write", d, 100);
    op(4'd8, 0, 3, 0, 22, 0, 1'b1);
    check("R8 no fault", {63'd0, fault_now}, 0);
    op(4'd10, 0, 3, 0, 0);
    check("R8 no chk", {63'd0, chk_fault}, 0);
    op(4'd11, 0, 1, 1, 0);
    check("R8 no cmp", {63'd0, cmp_valid}, 0);

    // R9 register 0
    op(4'd7, 1, 0, 0, 0, 64'd55);
    rd(7'd0, d, t);
    check("R9 port a", {d[62:0], t}, 0);
    src_b = 7'd0; #1;
    check("R9 port b", {rd_b_data[62:0], rd_b_tag}, 0);

    // R10 back-to-back bypass
    op(4'd5, 1, 2, 0, 23);
    op(4'd1, 1, 23, 23, 24);
    rd(7'd24, d, t);
    check("R10 bypass result", d, 14);
    op(4'd5, 1, 3, 0, 25);
    op(4'd5, 1, 25, 0, 26);
    rd(7'd26, d, t);
    check("R10 bypass tag", {63'd0, t}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule